// File: doc/BRIEF.md
# Noise Floor History Filter

This block smooths noise-floor readings taken by a radio receiver. It tracks six measurement slots: three receive chains on the control channel and three on the extension channel. Each slot keeps a short circular history of signed readings. On a `start` pulse the block takes one vector of raw 9-bit two's-complement readings and widens each one to a signed value. It then walks the slots one at a time and writes each enabled slot's reading into that slot's history.

Every slot starts in a settling window. While a slot is settling, its filtered output follows the newest reading. Each in-range reading shortens the window by one. A reading out of range resets the window to the full history depth. Once the window reaches zero, the filtered output becomes the median of the history. A small compare-and-swap engine works out that median over several cycles, one slot at a time.

The block also raises an interference flag when the slot-0 reading is above a signed 8-bit threshold chosen for the current band. When the measurement did not complete, the block reports a raw noise floor of zero and leaves every history as it was.

Top module: `nf_hist_filter`

## Requirements
- R1: A raw reading is 9 bits wide and occupies bits [9*s+8 : 9*s] of `raw_in` for slot s. When bit 8 is set the value is negative and equals the field minus 512; otherwise it equals the field.
- R2: After reset, every `nf_out` slot reads -110 (the max-good value), `raw_nf` is 0, and `intf`, `done` and `busy` are 0. Every history entry is -110, and every settling countdown is 5.
- R3: While a slot's countdown is non-zero, an in-range reading (from -140 to -60 inclusive) becomes that slot's filtered output and lowers the countdown by one.
- R4: While a slot's countdown is non-zero, a reading below -140 or above -60 reloads the countdown to the history depth (5) and leaves the filtered output unchanged. The reading is still written into the history.
- R5: While a slot's countdown is zero, its filtered output is the element at index (DEPTH-1)>>1 of its history sorted in descending order. That history includes the newest reading.
- R6: Each slot has its own write index. The index advances on each write to that slot and wraps to 0 after DEPTH-1, so the newest reading replaces the oldest entry.
- R7: On a completed measurement, `intf` becomes 1 when the slot-0 reading is greater than `thresh` read as signed 8-bit, and 0 otherwise. On an incomplete measurement `intf` becomes 0.
- R8: A `start` with `meas_done` low produces `done` on the next cycle with `raw_nf` = 0, and changes no history, index, countdown or filtered output.
- R9: `slot_en` is sampled at `start`. A slot whose bit is 0 keeps its history, index, countdown and filtered output unchanged.
- R10: After a completed `start`, `busy` is 1 from the next cycle until processing ends. `done` is then high for exactly one cycle, with `raw_nf` equal to the slot-0 filtered output. While the block is idle, `nf_out` does not change.
- R11: While a slot's countdown is zero, an out-of-range reading is written into the history and the countdown stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that accepts one reading vector; ignored while busy |
| meas_done | input | 1 | 1 = the measurement completed and `raw_in` is valid |
| raw_in | input | 54 | Six 9-bit raw readings, slot 0 in the low bits |
| slot_en | input | 6 | Per-slot enable; bit s enables slot s |
| thresh | input | 8 | Signed interference threshold for the current band |
| busy | output | 1 | Slots are being processed |
| done | output | 1 | One-cycle pulse at the end of an update |
| raw_nf | output | 16 | Reported noise floor: slot-0 filtered value, or 0 on an incomplete measurement |
| intf | output | 1 | Interference detected on slot 0 |
| nf_out | output | 96 | Six signed 16-bit filtered values, slot 0 in the low bits |

## Verification
The hardest state to reach is median mode that follows a reload. The bench first drives a slot through part of its settling window. It then feeds an out-of-range reading, which puts the countdown back to full. It then has to supply five more in-range readings before the median path is used at all. Incomplete measurements and masked slots are placed between these updates, so any history or index change they caused would show up later as a wrong median. A software model of the circular history and the descending sort supplies the expected value of every slot after each update.

// File: rtl/nf_hist_filter.sv
module nf_hist_filter #(
  parameter int SLOTS    = 6,
  parameter int DEPTH    = 5,
  parameter int RAW_W    = 9,
  parameter int OUT_W    = 16,
  parameter int THR_W    = 8,
  parameter int FILT_WIN = 5,
  parameter int MAX_GOOD = -110,
  parameter int MIN_BAD  = -140,
  parameter int MAX_HIGH = -60
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     meas_done,
  input  logic [SLOTS*RAW_W-1:0]   raw_in,
  input  logic [SLOTS-1:0]         slot_en,
  input  logic [THR_W-1:0]         thresh,
  output logic                     busy,
  output logic                     done,
  output logic [OUT_W-1:0]         raw_nf,
  output logic                     intf,
  output logic [SLOTS*OUT_W-1:0]   nf_out
);

  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CMAX   = (DEPTH > FILT_WIN) ? DEPTH : FILT_WIN;
  localparam int CNT_W  = $clog2(CMAX + 1);
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int PASS_W = $clog2(DEPTH + 1);
  localparam int MID    = (DEPTH - 1) >> 1;
  localparam logic signed [OUT_W-1:0] LO_V   = OUT_W'(MIN_BAD);
  localparam logic signed [OUT_W-1:0] HI_V   = OUT_W'(MAX_HIGH);
  localparam logic signed [OUT_W-1:0] GOOD_V = OUT_W'(MAX_GOOD);

  typedef enum logic [2:0] {S_IDLE, S_SLOT, S_SORT, S_PICK, S_NEXT} st_t;

  st_t                      st;
  logic [SLOT_W-1:0]        slot;
  logic [PASS_W-1:0]        pass;
  logic [SLOTS-1:0]         en_q;
  logic signed [OUT_W-1:0]  hist [SLOTS][DEPTH];
  logic [IDX_W-1:0]         widx [SLOTS];
  logic [CNT_W-1:0]         cnt  [SLOTS];
  logic signed [OUT_W-1:0]  filt [SLOTS];
  logic signed [OUT_W-1:0]  samp [SLOTS];
  logic signed [OUT_W-1:0]  srt    [DEPTH];
  logic signed [OUT_W-1:0]  srt_nx [DEPTH];

  function automatic logic signed [OUT_W-1:0] sx(input logic [RAW_W-1:0] r);
    return {{(OUT_W-RAW_W){r[RAW_W-1]}}, r};
  endfunction

  logic signed [OUT_W-1:0] cur_s, thr_x, raw0_x;
  logic                    in_rng;
  logic [IDX_W-1:0]        idx_nx;

  assign cur_s  = samp[slot];
  assign thr_x  = {{(OUT_W-THR_W){thresh[THR_W-1]}}, thresh};
  assign raw0_x = sx(raw_in[RAW_W-1:0]);
  assign in_rng = (cur_s >= LO_V) && (cur_s <= HI_V);
  assign idx_nx = (widx[slot] == IDX_W'(DEPTH-1)) ? '0 : widx[slot] + 1'b1;
  assign busy   = (st != S_IDLE);

  always_comb begin
    srt_nx = srt;
    for (int i = 0; i < DEPTH-1; i++) begin
      if ((i[0] == pass[0]) && (srt[i+1] > srt[i])) begin
        srt_nx[i]   = srt[i+1];
        srt_nx[i+1] = srt[i];
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_out
      assign nf_out[g*OUT_W +: OUT_W] = filt[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      slot   <= '0;
      pass   <= '0;
      en_q   <= '0;
      done   <= 1'b0;
      intf   <= 1'b0;
      raw_nf <= '0;
      for (int s = 0; s < SLOTS; s++) begin
        widx[s] <= '0;
        cnt[s]  <= CNT_W'(FILT_WIN);
        filt[s] <= GOOD_V;
        samp[s] <= '0;
        for (int d = 0; d < DEPTH; d++) hist[s][d] <= GOOD_V;
      end
      for (int d = 0; d < DEPTH; d++) srt[d] <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            if (meas_done) begin
              for (int s = 0; s < SLOTS; s++)
                samp[s] <= sx(raw_in[s*RAW_W +: RAW_W]);
              en_q <= slot_en;
              intf <= (raw0_x > thr_x);
              slot <= '0;
              st   <= S_SLOT;
            end else begin
              raw_nf <= '0;
              intf   <= 1'b0;
              done   <= 1'b1;
            end
          end
        end
        S_SLOT: begin
          if (en_q[slot]) begin
            hist[slot][widx[slot]] <= cur_s;
            widx[slot] <= idx_nx;
            if (cnt[slot] != '0) begin
              if (in_rng) begin
                cnt[slot]  <= cnt[slot] - 1'b1;
                filt[slot] <= cur_s;
              end else begin
                cnt[slot] <= CNT_W'(DEPTH);
              end
              st <= S_NEXT;
            end else begin
              for (int d = 0; d < DEPTH; d++)
                srt[d] <= (IDX_W'(d) == widx[slot]) ? cur_s : hist[slot][d];
              pass <= '0;
              st   <= S_SORT;
            end
          end else begin
            st <= S_NEXT;
          end
        end
        S_SORT: begin
          srt  <= srt_nx;
          pass <= pass + 1'b1;
          if (pass == PASS_W'(DEPTH-1)) st <= S_PICK;
        end
        S_PICK: begin
          filt[slot] <= srt[MID];
          st <= S_NEXT;
        end
        S_NEXT: begin
          if (slot == SLOT_W'(SLOTS-1)) begin
            done   <= 1'b1;
            raw_nf <= filt[0];
            st     <= S_IDLE;
          end else begin
            slot <= slot + 1'b1;
            st   <= S_SLOT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nf_hist_filter_chk.sv
module nf_hist_filter_chk #(
  parameter int SLOTS = 6,
  parameter int RAW_W = 9,
  parameter int OUT_W = 16,
  parameter int THR_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   meas_done,
  input logic [RAW_W-1:0]       raw0,
  input logic [THR_W-1:0]       thresh,
  input logic                   busy,
  input logic                   done,
  input logic [OUT_W-1:0]       raw_nf,
  input logic                   intf,
  input logic [SLOTS*OUT_W-1:0] nf_out
);

  logic signed [OUT_W-1:0] r0x, tx;
  assign r0x = {{(OUT_W-RAW_W){raw0[RAW_W-1]}}, raw0};
  assign tx  = {{(OUT_W-THR_W){thresh[THR_W-1]}}, thresh};

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(nf_out));

  // R8
  incomplete_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !meas_done) |=> (done && raw_nf == '0));

  // R7
  incomplete_intf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !meas_done) |=> !intf);

  // R7
  intf_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && meas_done) |=> (intf == (r0x > tx)));

endmodule

bind nf_hist_filter nf_hist_filter_chk #(
  .SLOTS(SLOTS), .RAW_W(RAW_W), .OUT_W(OUT_W), .THR_W(THR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .meas_done(meas_done),
  .raw0(raw_in[RAW_W-1:0]), .thresh(thresh), .busy(busy), .done(done),
  .raw_nf(raw_nf), .intf(intf), .nf_out(nf_out)
);

// File: tb/nf_hist_filter_test.sv
`timescale 1ns/1ps
module nf_hist_filter_test;
  localparam int SL = 6, D = 5, RW = 9, OW = 16;
  localparam int MAXG = -110, MINB = -140, MAXH = -60, WIN = 5;
  localparam int NV = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, meas_done = 1'b0;
  logic [SL*RW-1:0] raw_in = '0;
  logic [SL-1:0] slot_en = '0;
  logic [7:0] thresh = '0;
  logic busy, done, intf;
  logic [OW-1:0] raw_nf;
  logic [SL*OW-1:0] nf_out;

  always #10 clk = ~clk;

  nf_hist_filter uut (
    .clk(clk), .rst_n(rst_n), .start(start), .meas_done(meas_done),
    .raw_in(raw_in), .slot_en(slot_en), .thresh(thresh), .busy(busy),
    .done(done), .raw_nf(raw_nf), .intf(intf), .nf_out(nf_out)
  );

  // {meas_done, slot_en, thresh, s5..s0}
  localparam logic [68:0] VEC [NV] = '{
    {1'b1, 6'h3F, 8'hA6, 9'h1A1, 9'h1B0, 9'h188, 9'h1A6, 9'h192, 9'h19C},
    {1'b1, 6'h3F, 8'hA6, 9'h188, 9'h192, 9'h1BA, 9'h19C, 9'h1A1, 9'h1B0},
    {1'b0, 6'h3F, 8'hA6, 9'h1CE, 9'h1CE, 9'h1CE, 9'h1CE, 9'h1CE, 9'h1CE},
    {1'b1, 6'h3F, 8'hA6, 9'h1BA, 9'h1A1, 9'h19C, 9'h1B0, 9'h188, 9'h014},
    {1'b1, 6'h2D, 8'h9C, 9'h1A6, 9'h138, 9'h1A1, 9'h192, 9'h1CE, 9'h192},
    {1'b1, 6'h3F, 8'h9C, 9'h192, 9'h19C, 9'h1B0, 9'h188, 9'h19C, 9'h1A1},
    {1'b1, 6'h3F, 8'h9C, 9'h19C, 9'h1A6, 9'h192, 9'h1A1, 9'h1BA, 9'h188},
    {1'b1, 6'h3F, 8'hA6, 9'h1A1, 9'h188, 9'h138, 9'h192, 9'h1B0, 9'h1A6},
    {1'b1, 6'h3F, 8'hA6, 9'h1B0, 9'h192, 9'h1A1, 9'h1BA, 9'h1A6, 9'h19C},
    {1'b1, 6'h3F, 8'hA6, 9'h192, 9'h1A1, 9'h1A6, 9'h19C, 9'h188, 9'h1BA},
    {1'b1, 6'h36, 8'hA6, 9'h188, 9'h1BA, 9'h19C, 9'h1B0, 9'h1A1, 9'h1CE},
    {1'b1, 6'h3F, 8'hA6, 9'h1BA, 9'h19C, 9'h188, 9'h1A6, 9'h138, 9'h192},
    {1'b0, 6'h3F, 8'h9C, 9'h192, 9'h192, 9'h192, 9'h192, 9'h192, 9'h192},
    {1'b1, 6'h3F, 8'h9C, 9'h1A1, 9'h1A6, 9'h1BA, 9'h192, 9'h1CE, 9'h1B0},
    {1'b1, 6'h3F, 8'h9C, 9'h1A6, 9'h1B0, 9'h192, 9'h188, 9'h19C, 9'h1A1},
    {1'b1, 6'h3F, 8'h9C, 9'h19C, 9'h188, 9'h1B0, 9'h1A1, 9'h192, 9'h1A6}
  };

  int checks = 0, errors = 0;
  int mh [SL][D];
  int mi [SL], mc [SL], mf [SL];
  int mraw;
  int mintf;
  string tg [SL];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sx9(input logic [8:0] r);
    return r[8] ? int'(r) - 512 : int'(r);
  endfunction

  function automatic int med(input int s);
    int a [D];
    for (int j = 0; j < D; j++) a[j] = mh[s][j];
    for (int p = 0; p < D; p++)
      for (int j = 0; j < D-1; j++)
        if (a[j+1] > a[j]) begin
          int t = a[j]; a[j] = a[j+1]; a[j+1] = t;
        end
    return a[(D-1)>>1];
  endfunction

  task automatic model(input logic [68:0] v);
    if (!v[68]) begin
      mraw = 0; mintf = 0;
      for (int s = 0; s < SL; s++) tg[s] = "R8";
      return;
    end
    mintf = (sx9(v[8:0]) > int'($signed(v[61:54]))) ? 1 : 0;
    for (int s = 0; s < SL; s++) begin
      if (!v[62+s]) begin
        tg[s] = "R9";
      end else begin
        int x = sx9(v[s*9 +: 9]);
        mh[s][mi[s]] = x;
        mi[s] = (mi[s] + 1) % D;
        if (mc[s] > 0) begin
          if (x < MINB || x > MAXH) begin mc[s] = D; tg[s] = "R4"; end
          else begin mc[s]--; mf[s] = x; tg[s] = "R3 R1"; end
        end else begin
          mf[s] = med(s);
          tg[s] = (x < MINB || x > MAXH) ? "R11" : "R5 R6";
        end
      end
    end
    mraw = mf[0];
  endtask

  task automatic run(input logic [68:0] v);
    @(negedge clk);
    meas_done = v[68]; slot_en = v[67:62]; thresh = v[61:54]; raw_in = v[53:0];
    start = 1'b1;
    model(v);
    @(negedge clk);
    start = 1'b0;
    if (v[68]) chk("R10 busy after start", int'(busy), 1);
    else       chk("R8 done next cycle", int'(done), 1);
    for (int k = 0; k < 200 && !done; k++) @(negedge clk);
    chk("R10 done seen", int'(done), 1);
    chk(v[68] ? "R10 raw_nf" : "R8 raw_nf", int'($signed(raw_nf)), mraw);
    chk("R7 intf", int'(intf), mintf);
    for (int s = 0; s < SL; s++)
      chk($sformatf("%s slot%0d", tg[s], s), int'($signed(nf_out[s*OW +: OW])), mf[s]);
    @(negedge clk);
    chk("R10 done single", int'(done), 0);
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < SL; s++) begin
      mi[s] = 0; mc[s] = WIN; mf[s] = MAXG;
      for (int d = 0; d < D; d++) mh[s][d] = MAXG;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 raw_nf", int'($signed(raw_nf)), 0);
    chk("R2 intf", int'(intf), 0);
    chk("R2 done", int'(done), 0);
    chk("R2 busy", int'(busy), 0);
    for (int s = 0; s < SL; s++)
      chk($sformatf("R2 slot%0d", s), int'($signed(nf_out[s*OW +: OW])), MAXG);

    for (int n = 0; n < NV; n++) run(VEC[n]);

    // R1: large positive field against the largest threshold
    run({1'b1, 6'h3F, 8'h7F, 9'h192, 9'h192, 9'h192, 9'h192, 9'h192, 9'h0FF});
    // R1: most negative field against the smallest threshold
    run({1'b1, 6'h3F, 8'h80, 9'h192, 9'h192, 9'h192, 9'h192, 9'h192, 9'h100});
    // R7: reading equal to threshold gives no flag
    run({1'b1, 6'h3F, 8'hA6, 9'h192, 9'h192, 9'h192, 9'h192, 9'h192, 9'h1A6});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule